// File: doc/BRIEF.md
# Strided Tile Transfer Sequencer

This block moves a two-dimensional tile between a row-organised tile register file and a memory port. A tile register holds RLEN/32 rows, each RLEN bits wide. Each row travels as one memory line, so a transfer is a chain of single-line requests. A command selects the direction (load or store) and a starting register. It also selects one of two addressing schemes. In strided mode, row r lives at base + r × stride. In whole-register mode, a group of 1, 2, 4 or 8 consecutive registers is packed back to back in memory, and the stride is not used.

In strided mode the command also gives an active row count, an element width and an active column count. Only the leading bytes of each row are moved, and only the active rows. On a load, every other byte of the register is kept as it was. A streaming flag on the command is passed to the memory port as a hint. It does not change the request sequence. The sequencer issues one request at a time in row order. It raises a single-cycle completion pulse after the last load response or the last store acknowledgement.

Top module: `tile_xfer_engine`

## Requirements
- R1: `cmd_ready` is high exactly when the sequencer is idle. A command is taken only on a cycle where `cmd_valid` and `cmd_ready` are both high. A command presented while busy has no effect on the requests, on the tile registers or on the number of completion pulses.
- R2: In strided mode, `cmd_count` (2 bits) selects count+1 rows. Row r is requested at byte address `cmd_base + r*cmd_stride`, and requests are issued in ascending row order.
- R3: A strided load writes row r of register `cmd_reg` at tile address `{reg, row}`. Only bytes 0 .. (cols << ew) − 1 are written, where `cmd_cols` gives the element count and `cmd_ew` is 0 = byte, 1 = half-word, 2 = word, 3 = double-word. Rows at or beyond the active count, and bytes beyond that span, are left unchanged.
- R4: A strided store reads each active row from the tile registers and sends it with `mem_req_we` high. `mem_req_be` covers the same byte span as in R3.
- R5: In whole-register mode, `cmd_count` = k moves 2^k registers, starting at `cmd_reg` and going up modulo NREG. Rows go in ascending register order, then ascending row order, at `cmd_base + i*RLEN/8`. All bytes are enabled, and `cmd_stride` is ignored.
- R6: At most one memory request is outstanding. After a request is accepted, `mem_req_valid` stays low until the response arrives. A request that is not yet accepted keeps its address stable.
- R7: `done` pulses for one cycle, in the cycle after the final response or acknowledgement. There is exactly one pulse per accepted command.
- R8: `mem_req_hint` carries the command's streaming flag on every request of that command. The addresses and tile data are the same as for the command without the flag.
- R9: After reset the sequencer is idle: `cmd_ready` is high, and `mem_req_valid`, `trf_we` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle, command can be taken |
| cmd_store | input | 1 | 1 = store, 0 = load |
| cmd_whole | input | 1 | 1 = whole-register mode |
| cmd_stream | input | 1 | Streaming hint |
| cmd_base | input | AW | Byte base address |
| cmd_stride | input | AW | Byte stride between rows (strided mode) |
| cmd_ew | input | 2 | Element width code |
| cmd_reg | input | log2(NREG) | First tile register |
| cmd_count | input | 2 | Row count − 1 (strided) or log2 of register count (whole) |
| cmd_cols | input | log2(RLEN/8)+1 | Active elements per row (strided) |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_we | output | 1 | Request is a write |
| mem_req_hint | output | 1 | Streaming hint |
| mem_req_addr | output | AW | Byte address of the line |
| mem_req_wdata | output | RLEN | Write line |
| mem_req_be | output | RLEN/8 | Byte enables |
| mem_rsp_valid | input | 1 | Read data or write acknowledgement |
| mem_rsp_rdata | input | RLEN | Read line |
| trf_we | output | 1 | Tile row write strobe |
| trf_waddr | output | log2(NREG)+log2(RLEN/32) | Tile row write address |
| trf_wdata | output | RLEN | Tile row write data |
| trf_wbe | output | RLEN/8 | Tile row byte enables |
| trf_raddr | output | log2(NREG)+log2(RLEN/32) | Tile row read address |
| trf_rdata | input | RLEN | Tile row read data, combinational |
| done | output | 1 | Completion pulse |

## Verification
The bench builds the block with RLEN = 128 and NREG = 8. That gives four rows of 16-byte lines per register, so every element width can be reached with `cmd_cols` of 16 or fewer, and partial-byte masks show up inside one line. With eight registers, a four-register whole-mode load covers sixteen rows. A two-register whole-mode group starting at register 7 reaches the wrap back to register 0. The memory model stalls at irregular points and answers after a random delay, so the one-outstanding and hold rules are exercised under back-pressure.

// File: rtl/tile_xfer_engine.sv
module tile_xfer_engine #(
  parameter int RLEN = 128,
  parameter int NREG = 8,
  parameter int AW   = 32
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic                                        cmd_valid,
  output logic                                        cmd_ready,
  input  logic                                        cmd_store,
  input  logic                                        cmd_whole,
  input  logic                                        cmd_stream,
  input  logic [AW-1:0]                               cmd_base,
  input  logic [AW-1:0]                               cmd_stride,
  input  logic [1:0]                                  cmd_ew,
  input  logic [$clog2(NREG)-1:0]                     cmd_reg,
  input  logic [1:0]                                  cmd_count,
  input  logic [$clog2(RLEN/8):0]                     cmd_cols,
  output logic                                        mem_req_valid,
  input  logic                                        mem_req_ready,
  output logic                                        mem_req_we,
  output logic                                        mem_req_hint,
  output logic [AW-1:0]                               mem_req_addr,
  output logic [RLEN-1:0]                             mem_req_wdata,
  output logic [RLEN/8-1:0]                           mem_req_be,
  input  logic                                        mem_rsp_valid,
  input  logic [RLEN-1:0]                             mem_rsp_rdata,
  output logic                                        trf_we,
  output logic [$clog2(NREG)+$clog2(RLEN/32)-1:0]     trf_waddr,
  output logic [RLEN-1:0]                             trf_wdata,
  output logic [RLEN/8-1:0]                           trf_wbe,
  output logic [$clog2(NREG)+$clog2(RLEN/32)-1:0]     trf_raddr,
  input  logic [RLEN-1:0]                             trf_rdata,
  output logic                                        done
);
  localparam int ROWS  = RLEN / 32;
  localparam int BYTES = RLEN / 8;
  localparam int RW    = $clog2(ROWS);
  localparam int GW    = $clog2(NREG);
  localparam int TW    = GW + RW;
  localparam int CW    = $clog2(BYTES) + 1;
  localparam int IW    = RW + 3;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} state_t;

  state_t          state_q;
  logic            store_q, hint_q, done_q;
  logic [GW-1:0]   reg_q;
  logic [AW-1:0]   addr_q, step_q;
  logic [IW-1:0]   idx_q, last_q;
  logic [BYTES-1:0] mask_q, cmd_mask;
  logic [CW+2:0]   cmd_nb;
  logic [GW-1:0]   reg_cur;
  logic [TW-1:0]   tile_addr;
  logic            accept;

  assign accept = cmd_valid && (state_q == S_IDLE);
  assign cmd_nb = {3'b000, cmd_cols} << cmd_ew;

  always_comb begin
    for (int b = 0; b < BYTES; b++) cmd_mask[b] = int'(cmd_nb) > b;
  end

  assign reg_cur   = reg_q + GW'(idx_q[IW-1:RW]);
  assign tile_addr = {reg_cur, idx_q[RW-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      store_q <= 1'b0;
      hint_q  <= 1'b0;
      done_q  <= 1'b0;
      reg_q   <= '0;
      addr_q  <= '0;
      step_q  <= '0;
      idx_q   <= '0;
      last_q  <= '0;
      mask_q  <= '0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        S_IDLE: if (accept) begin
          store_q <= cmd_store;
          hint_q  <= cmd_stream;
          reg_q   <= cmd_reg;
          addr_q  <= cmd_base;
          idx_q   <= '0;
          step_q  <= cmd_whole ? AW'(BYTES) : cmd_stride;
          last_q  <= cmd_whole ? IW'((ROWS << cmd_count) - 1) : IW'(cmd_count);
          mask_q  <= cmd_whole ? '1 : cmd_mask;
          state_q <= S_REQ;
        end
        S_REQ: if (mem_req_ready) state_q <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          if (idx_q == last_q) begin
            state_q <= S_IDLE;
            done_q  <= 1'b1;
          end else begin
            idx_q   <= idx_q + 1'b1;
            addr_q  <= addr_q + step_q;
            state_q <= S_REQ;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign cmd_ready     = state_q == S_IDLE;
  assign mem_req_valid = state_q == S_REQ;
  assign mem_req_we    = store_q;
  assign mem_req_hint  = hint_q;
  assign mem_req_addr  = addr_q;
  assign mem_req_wdata = trf_rdata;
  assign mem_req_be    = mask_q;
  assign trf_raddr     = tile_addr;
  assign trf_we        = (state_q == S_WAIT) && mem_rsp_valid && !store_q;
  assign trf_waddr     = tile_addr;
  assign trf_wdata     = mem_rsp_rdata;
  assign trf_wbe       = mask_q;
  assign done          = done_q;
endmodule

// File: rtl/tile_xfer_engine_chk.sv
module tile_xfer_engine_chk #(
  parameter int RLEN = 128,
  parameter int AW   = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic          cmd_whole,
  input logic [AW-1:0] cmd_base,
  input logic [AW-1:0] cmd_stride,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic [AW-1:0] mem_req_addr,
  input logic          mem_rsp_valid,
  input logic          trf_we,
  input logic          done
);
  logic [AW-1:0] exp_addr, exp_step;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exp_addr <= '0;
      exp_step <= '0;
    end else if (cmd_valid && cmd_ready) begin
      exp_addr <= cmd_base;
      exp_step <= cmd_whole ? AW'(RLEN / 8) : cmd_stride;
    end else if (mem_req_valid && mem_req_ready) begin
      exp_addr <= exp_addr + exp_step;
    end
  end

  AST_ADDR_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_addr == exp_addr); // R2
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready) |=> !mem_req_valid); // R6
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_DONE_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mem_rsp_valid)); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!mem_req_valid && !trf_we)); // R1
endmodule

bind tile_xfer_engine tile_xfer_engine_chk #(.RLEN(RLEN), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_whole(cmd_whole), .cmd_base(cmd_base), .cmd_stride(cmd_stride),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
  .trf_we(trf_we), .done(done)
);

// File: tb/tile_xfer_engine_tb_top.sv
module tile_xfer_engine_tb_top;
  localparam int RLEN = 128, NREG = 8, AW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic cmd_valid = 0, cmd_store = 0, cmd_whole = 0, cmd_stream = 0;
  logic [31:0] cmd_base = 0, cmd_stride = 0;
  logic [1:0] cmd_ew = 0, cmd_count = 0;
  logic [2:0] cmd_reg = 0;
  logic [4:0] cmd_cols = 0;
  logic cmd_ready, mem_req_valid, mem_req_ready, mem_req_we, mem_req_hint;
  logic [31:0] mem_req_addr;
  logic [127:0] mem_req_wdata, trf_wdata, trf_rdata, rsp_q;
  logic [15:0] mem_req_be, trf_wbe;
  logic trf_we, done, rsp_v, pend;
  logic [4:0] trf_waddr, trf_raddr;
  logic [1:0] dly;
  logic [7:0] lfsr;

  logic [127:0] mem_m [64];
  logic [127:0] trf_m [32];
  logic [31:0]  log_addr [512];
  logic         log_hint [512];
  logic         log_we   [512];
  int log_n, done_cnt;
  int total = 0, fails = 0;

  tile_xfer_engine #(.RLEN(RLEN), .NREG(NREG), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_store(cmd_store), .cmd_whole(cmd_whole), .cmd_stream(cmd_stream),
    .cmd_base(cmd_base), .cmd_stride(cmd_stride), .cmd_ew(cmd_ew), .cmd_reg(cmd_reg),
    .cmd_count(cmd_count), .cmd_cols(cmd_cols), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we), .mem_req_hint(mem_req_hint),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata), .mem_req_be(mem_req_be),
    .mem_rsp_valid(rsp_v), .mem_rsp_rdata(rsp_q), .trf_we(trf_we), .trf_waddr(trf_waddr),
    .trf_wdata(trf_wdata), .trf_wbe(trf_wbe), .trf_raddr(trf_raddr), .trf_rdata(trf_rdata),
    .done(done)
  );

  function automatic logic [127:0] pat(int i, int salt);
    logic [127:0] r;
    for (int j = 0; j < 16; j++) r[j*8 +: 8] = 8'(i * 17 + j * 3 + salt);
    return r;
  endfunction

  function automatic logic [15:0] mk_mask(int cols, int ew);
    logic [15:0] m;
    for (int b = 0; b < 16; b++) m[b] = b < (cols << ew);
    return m;
  endfunction

  function automatic logic [127:0] merge(logic [127:0] old, logic [127:0] nw, logic [15:0] m);
    logic [127:0] r;
    for (int b = 0; b < 16; b++) r[b*8 +: 8] = m[b] ? nw[b*8 +: 8] : old[b*8 +: 8];
    return r;
  endfunction

  assign trf_rdata     = trf_m[trf_raddr];
  assign mem_req_ready = !pend && !rsp_v && (lfsr[0] | lfsr[1]);

  always @(posedge clk) begin
    if (!rst_n) begin
      pend <= 0; rsp_v <= 0; dly <= 0; lfsr <= 8'hA5; log_n <= 0; done_cnt <= 0;
      rsp_q <= '0;
      for (int i = 0; i < 64; i++) mem_m[i] <= pat(i, 1);
      for (int i = 0; i < 32; i++) trf_m[i] <= pat(i, 90);
    end else begin
      lfsr  <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      rsp_v <= 1'b0;
      if (done) done_cnt <= done_cnt + 1;
      if (trf_we) trf_m[trf_waddr] <= merge(trf_m[trf_waddr], trf_wdata, trf_wbe);
      if (pend) begin
        if (dly == 0) begin rsp_v <= 1'b1; pend <= 1'b0; end
        else dly <= dly - 1'b1;
      end
      if (mem_req_valid && mem_req_ready) begin
        pend  <= 1'b1;
        dly   <= lfsr[3:2];
        rsp_q <= mem_m[mem_req_addr[9:4]];
        if (mem_req_we)
          mem_m[mem_req_addr[9:4]] <= merge(mem_m[mem_req_addr[9:4]], mem_req_wdata, mem_req_be);
        log_addr[log_n] <= mem_req_addr;
        log_hint[log_n] <= mem_req_hint;
        log_we[log_n]   <= mem_req_we;
        log_n <= log_n + 1;
      end
    end
  end

  task automatic chk(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(bit st, bit wh, bit sm, int base, int stride, int ew, int rg, int cnt, int cols);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_store = st; cmd_whole = wh; cmd_stream = sm;
    cmd_base = base; cmd_stride = stride; cmd_ew = 2'(ew);
    cmd_reg = 3'(rg); cmd_count = 2'(cnt); cmd_cols = 5'(cols);
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 3000) begin @(negedge clk); n++; end
    chk(done, "R7 done seen", 128'(done), 1);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk(cmd_ready == 1, "R9 cmd_ready", 128'(cmd_ready), 1);
    chk(mem_req_valid == 0, "R9 mem_req_valid", 128'(mem_req_valid), 0);
    chk(trf_we == 0, "R9 trf_we", 128'(trf_we), 0);
    chk(done == 0, "R9 done", 128'(done), 0);
  endtask

  task automatic t_strided_load(int rg, int base, int stride, int cnt, int ew, int cols, bit sm);
    logic [127:0] old_t [32];
    logic [127:0] old_m [64];
    logic [15:0] m;
    int n0, d0, rows;
    for (int i = 0; i < 32; i++) old_t[i] = trf_m[i];
    for (int i = 0; i < 64; i++) old_m[i] = mem_m[i];
    n0 = log_n; d0 = done_cnt; rows = cnt + 1; m = mk_mask(cols, ew);
    send(0, 0, sm, base, stride, ew, rg, cnt, cols);
    wait_done();
    chk(log_n - n0 == rows, "R2 request count", 128'(log_n - n0), 128'(rows));
    for (int r = 0; r < rows; r++) begin
      chk(log_addr[n0 + r] == 32'(base + r * stride), "R2 row address",
          128'(log_addr[n0 + r]), 128'(base + r * stride));
      chk(log_hint[n0 + r] == sm, "R8 hint", 128'(log_hint[n0 + r]), 128'(sm));
    end
    for (int r = 0; r < 4; r++) begin
      logic [127:0] e;
      e = (r < rows) ? merge(old_t[rg*4 + r], old_m[((base + r * stride) >> 4) & 63], m)
                     : old_t[rg*4 + r];
      chk(trf_m[rg*4 + r] == e, "R3 tile row", trf_m[rg*4 + r], e);
    end
    chk(done_cnt - d0 == 1, "R7 one pulse", 128'(done_cnt - d0), 1);
  endtask

  task automatic t_strided_store(int rg, int base, int stride, int cnt, int ew, int cols);
    logic [127:0] old_m [64];
    logic [15:0] m;
    int n0, rows;
    for (int i = 0; i < 64; i++) old_m[i] = mem_m[i];
    n0 = log_n; rows = cnt + 1; m = mk_mask(cols, ew);
    send(1, 0, 0, base, stride, ew, rg, cnt, cols);
    wait_done();
    chk(log_n - n0 == rows, "R4 request count", 128'(log_n - n0), 128'(rows));
    for (int r = 0; r < rows; r++) begin
      int ln;
      logic [127:0] e;
      ln = ((base + r * stride) >> 4) & 63;
      e = merge(old_m[ln], trf_m[rg*4 + r], m);
      chk(log_we[n0 + r] == 1, "R4 write flag", 128'(log_we[n0 + r]), 1);
      chk(mem_m[ln] == e, "R4 memory line", mem_m[ln], e);
    end
    chk(mem_m[((base + rows * stride) >> 4) & 63] == old_m[((base + rows * stride) >> 4) & 63],
        "R4 row past count untouched", mem_m[((base + rows * stride) >> 4) & 63],
        old_m[((base + rows * stride) >> 4) & 63]);
  endtask

  task automatic t_whole(bit st, int rg, int k, int base);
    logic [127:0] old_m [64];
    logic [127:0] old_t [32];
    int n0, rows;
    for (int i = 0; i < 32; i++) old_t[i] = trf_m[i];
    for (int i = 0; i < 64; i++) old_m[i] = mem_m[i];
    n0 = log_n; rows = 4 << k;
    send(st, 1, 0, base, 32'h1230, 1, rg, k, 1);
    wait_done();
    chk(log_n - n0 == rows, "R5 request count", 128'(log_n - n0), 128'(rows));
    for (int i = 0; i < rows; i++) begin
      int ti, ln;
      ti = (((rg + i / 4) % 8) * 4) + (i % 4);
      ln = ((base + i * 16) >> 4) & 63;
      chk(log_addr[n0 + i] == 32'(base + i * 16), "R5 packed address",
          128'(log_addr[n0 + i]), 128'(base + i * 16));
      if (st) chk(mem_m[ln] == old_t[ti], "R5 whole store line", mem_m[ln], old_t[ti]);
      else    chk(trf_m[ti] == old_m[ln], "R5 whole load row", trf_m[ti], old_m[ln]);
    end
  endtask

  task automatic t_busy();
    int n0, d0;
    n0 = log_n; d0 = done_cnt;
    send(0, 0, 0, 32'h000, 32'h10, 2, 6, 3, 4);
    cmd_whole = 1; cmd_count = 2'd3; cmd_reg = 3'd1; cmd_base = 32'h300;
    cmd_valid = 1'b1;
    for (int i = 0; i < 3; i++) begin
      chk(cmd_ready == 0, "R1 busy not ready", 128'(cmd_ready), 0);
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    wait_done();
    chk(log_n - n0 == 4, "R1 busy command ignored", 128'(log_n - n0), 4);
    chk(log_addr[n0 + 3] == 32'h30, "R1 last address of first command",
        128'(log_addr[n0 + 3]), 128'h30);
    chk(done_cnt - d0 == 1, "R1 single pulse", 128'(done_cnt - d0), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_strided_load(2, 32'h100, 32'h40, 3, 2, 4, 0);
    t_strided_load(5, 32'h050, 32'h20, 1, 1, 3, 0);
    t_strided_load(0, 32'h000, 32'h20, 3, 3, 2, 0);
    t_strided_load(3, 32'h100, 32'h40, 3, 2, 4, 1);
    t_strided_store(1, 32'h080, 32'h30, 2, 0, 5);
    t_whole(0, 4, 2, 32'h200);
    t_whole(1, 7, 1, 32'h340);
    t_busy();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule